// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of peripherals and a processor core. Peripherals raise requests on seven priority levels. The processor supplies a 3-bit current priority mask from its status word. Each clock, the block finds the most urgent pending request. It raises a registered interrupt line when that request beats the mask, and it reports the level alongside. The top level is treated as nonmaskable and edge-triggered: it is always taken, even when the mask is at its maximum.

When the core acknowledges, the block freezes the chosen level. For one cycle it drives a one-hot acknowledge to that level. It then forms an 8-bit vector number in one of two ways:

- For a level configured as vectored, the number is captured from the peripheral's identification byte on the data input.
- For a nonvectored level, the number is produced from a fixed base plus the level.

The vector number and the handler address (number times four) are presented for one cycle with a valid strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq_o`, `iack_o` and `vec_valid_o` are all zero.
- R2: Request bit k of `req_i` stands for level k+1. A level from 1 to 6 raises `irq_o` one clock after it is sampled only if it is strictly greater than `cur_mask_i`. A level equal to or below the mask, or any such level with the mask at 7, leaves `irq_o` low.
- R3: When several levels are pending, `irq_lvl_o` reports the highest one, and it is never 0 while `irq_o` is high.
- R4: Level 7 (bit 6 of `req_i`) is accepted on a rising edge regardless of the mask. A request held high after it has been acknowledged does not raise `irq_o` again.
- R5: `ack_i` sampled while `irq_o` is high produces, on the next cycle only, `iack_o` with bit (level-1) set. `irq_o` stays low during that cycle and the vector cycle that follows. `ack_i` while `irq_o` is low is ignored.
- R6: For a level whose bit in `vec_mode_i` is 1 (vectored), the vector number is `id_data_i` sampled during the acknowledge cycle. It appears with `vec_valid_o` high for one cycle right after the acknowledge cycle.
- R7: For a level whose `vec_mode_i` bit is 0 (nonvectored), the vector number is 24 plus the level, for example 25 for level 1 and 31 for level 7.
- R8: `vec_addr_o` is the 10-bit vector number times four, so vector 255 gives 1020.
- R9: The level chosen at acknowledge is used for the acknowledge and the vector even if `req_i` changes during the acknowledge cycle.
- R10: A level-7 rising edge that arrives during another level's acknowledge is held. It raises `irq_o` with level 7 in the cycle after the vector cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Requests, bit k = level k+1; bit 6 is the nonmaskable level |
| vec_mode_i | input | 7 | Per-level servicing mode: 1 vectored, 0 nonvectored |
| cur_mask_i | input | 3 | Current processor priority mask |
| ack_i | input | 1 | Core acknowledge of the presented interrupt |
| id_data_i | input | 8 | Identification byte from the acknowledged peripheral |
| irq_o | output | 1 | Interrupt request to the core |
| irq_lvl_o | output | 3 | Level of the presented interrupt |
| iack_o | output | 7 | One-hot acknowledge to the selected level |
| vec_valid_o | output | 1 | Vector number and address valid |
| vec_num_o | output | 8 | Vector number |
| vec_addr_o | output | 10 | Handler address, vector number times four |

## Verification
Two functions can coincide: a new nonmaskable edge can arrive while the vector of a lower level is still being formed. The bench provokes this by raising bit 6 of `req_i` inside the acknowledge cycle of a level-2 interrupt. The bench then expects the level-2 vector (26) to come out unharmed, followed one cycle later by `irq_o` with level 7. In the same spirit, the requests are changed during a level-5 acknowledge, and the vector must still belong to level 5.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {ST_IDLE, ST_IACK} ack_state_e;
endpackage

// File: rtl/prio_irq_nmi_edge.sv
module prio_irq_nmi_edge (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic clr_i,
  output logic hit_o
);
  logic prev_q, pend_q, rise;

  assign rise  = raw_i & ~prev_q;
  assign hit_o = pend_q | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= raw_i;
      pend_q <= rise | (pend_q & ~clr_i);
    end
  end

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_i) |=> pend_q); // R10
endmodule

// File: rtl/prio_irq_enc.sv
module prio_irq_enc #(
  parameter int NLVL = 7,
  localparam int LW = $clog2(NLVL + 1)
) (
  input  logic [NLVL-1:0] req_i,
  input  logic [LW-1:0]   mask_i,
  output logic [LW-1:0]   top_lvl_o,
  output logic            ok_o
);
  always_comb begin
    top_lvl_o = '0;
    for (int k = 0; k < NLVL; k++) begin
      if (req_i[k]) top_lvl_o = LW'(k + 1);
    end
    ok_o = (top_lvl_o == LW'(NLVL)) || (top_lvl_o > mask_i);
  end
endmodule

// File: rtl/prio_irq_vec.sv
module prio_irq_vec #(
  parameter int NLVL = 7,
  parameter int VW   = 8,
  parameter int BASE = 24,
  localparam int LW = $clog2(NLVL + 1),
  localparam int AW = VW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [LW-1:0] lvl_i,
  input  logic          vectored_i,
  input  logic [VW-1:0] id_i,
  output logic          valid_o,
  output logic [VW-1:0] num_o,
  output logic [AW-1:0] addr_o
);
  logic [VW-1:0] num_nx;

  assign num_nx = vectored_i ? id_i : (VW'(BASE) + VW'(lvl_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      num_o   <= '0;
      addr_o  <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        num_o  <= num_nx;
        addr_o <= {num_nx, 2'b00};
      end
    end
  end

  AST_VEC_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(load_i)); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NLVL = 7,
  parameter int VW   = 8,
  parameter int BASE = 24,
  localparam int LW = $clog2(NLVL + 1),
  localparam int AW = VW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] req_i,
  input  logic [NLVL-1:0] vec_mode_i,
  input  logic [LW-1:0]   cur_mask_i,
  input  logic            ack_i,
  input  logic [VW-1:0]   id_data_i,
  output logic            irq_o,
  output logic [LW-1:0]   irq_lvl_o,
  output logic [NLVL-1:0] iack_o,
  output logic            vec_valid_o,
  output logic [VW-1:0]   vec_num_o,
  output logic [AW-1:0]   vec_addr_o
);
  import prio_irq_pkg::*;

  ack_state_e      st_q;
  logic            irq_q;
  logic [LW-1:0]   lvl_q, sel_q, top_lvl;
  logic [NLVL-1:0] iack_q, req_eff;
  logic            nmi_hit, ok, take, nmi_clr;

  assign take    = (st_q == ST_IDLE) && ack_i && irq_q;
  assign nmi_clr = take && (lvl_q == LW'(NLVL));

  prio_irq_nmi_edge u_nmi (
    .clk(clk), .rst(rst), .raw_i(req_i[NLVL-1]), .clr_i(nmi_clr), .hit_o(nmi_hit)
  );

  assign req_eff = {nmi_hit, req_i[NLVL-2:0]};

  prio_irq_enc #(.NLVL(NLVL)) u_enc (
    .req_i(req_eff), .mask_i(cur_mask_i), .top_lvl_o(top_lvl), .ok_o(ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      irq_q  <= 1'b0;
      lvl_q  <= '0;
      sel_q  <= '0;
      iack_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            st_q   <= ST_IACK;
            sel_q  <= lvl_q;
            iack_q <= NLVL'(1) << (lvl_q - LW'(1));
            irq_q  <= 1'b0;
          end else begin
            irq_q <= ok;
            lvl_q <= ok ? top_lvl : '0;
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          iack_q <= '0;
          irq_q  <= 1'b0;
        end
      endcase
    end
  end

  prio_irq_vec #(.NLVL(NLVL), .VW(VW), .BASE(BASE)) u_vec (
    .clk(clk), .rst(rst), .load_i(st_q == ST_IACK), .lvl_i(sel_q),
    .vectored_i(|(vec_mode_i & iack_q)), .id_i(id_data_i),
    .valid_o(vec_valid_o), .num_o(vec_num_o), .addr_o(vec_addr_o)
  );

  assign irq_o     = irq_q;
  assign irq_lvl_o = lvl_q;
  assign iack_o    = iack_q;

  AST_IACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(iack_o)); // R5
  AST_ACK_GRANT: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o && iack_o == '0) |=> (iack_o != '0 && !irq_o)); // R5
  AST_IACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    (iack_o != '0) |=> (iack_o == '0 && !irq_o && vec_valid_o)); // R6
  AST_MASK_RESPECT: assert property (@(posedge clk) disable iff (rst)
    (irq_o && irq_lvl_o != LW'(NLVL)) |-> (irq_lvl_o > $past(cur_mask_i))); // R2
  AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_lvl_o != '0)); // R3
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] req_i = '0, vec_mode_i = '0;
  logic [2:0] cur_mask_i = '0;
  logic       ack_i = 1'b0;
  logic [7:0] id_data_i = '0;
  logic       irq_o, vec_valid_o;
  logic [2:0] irq_lvl_o;
  logic [6:0] iack_o;
  logic [7:0] vec_num_o;
  logic [9:0] vec_addr_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .vec_mode_i(vec_mode_i),
    .cur_mask_i(cur_mask_i), .ack_i(ack_i), .id_data_i(id_data_i),
    .irq_o(irq_o), .irq_lvl_o(irq_lvl_o), .iack_o(iack_o),
    .vec_valid_o(vec_valid_o), .vec_num_o(vec_num_o), .vec_addr_o(vec_addr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: compare every produced vector against the scoreboard
  always @(negedge clk) begin
    if (!rst && vec_valid_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5: actual unexpected vector %0h expected none", vec_num_o);
      end else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " num"}, 32'(vec_num_o), 32'(e[17:10]));
        check({t, " R8 addr"}, 32'(vec_addr_o), 32'(e[9:0]));
      end
    end
  end

  // driver: acknowledge the presented interrupt and queue the expected vector
  task automatic do_ack(input logic [2:0] lvl, input logic [7:0] exp_num,
                        input logic [7:0] id, input logic [6:0] req_mid, input string tag);
    check({tag, " R3 irq"}, 32'(irq_o), 32'd1);
    check({tag, " R3 lvl"}, 32'(irq_lvl_o), 32'(lvl));
    ack_i = 1'b1;
    exp_q.push_back({exp_num, {exp_num, 2'b00}});
    tag_q.push_back(tag);
    step();
    ack_i = 1'b0;
    id_data_i = id;
    req_i = req_mid;
    check({tag, " R5 iack"}, 32'(iack_o), 32'(7'(1) << (lvl - 3'd1)));
    check({tag, " R5 irq low in iack"}, 32'(irq_o), 32'd0);
    step();
    check({tag, " R5 irq low in vec"}, 32'(irq_o), 32'd0);
    check({tag, " R5 iack gone"}, 32'(iack_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check("R1 irq", 32'(irq_o), 0);
    check("R1 iack", 32'(iack_o), 0);
    check("R1 vec_valid", 32'(vec_valid_o), 0);
    rst = 1'b0;
    step();
    check("R1 irq after reset", 32'(irq_o), 0);

    cur_mask_i = 3; req_i = 7'b0000100; step();
    check("R2 equal to mask", 32'(irq_o), 0);
    req_i = 7'b0001000; step();
    check("R2 above mask irq", 32'(irq_o), 1);
    check("R2 above mask lvl", 32'(irq_lvl_o), 4);

    cur_mask_i = 0; req_i = 7'b0011010; step();
    do_ack(5, 8'd29, 8'h00, 7'b0111010, "R9 R7 lvl5");
    req_i = '0; step(); step();

    vec_mode_i = 7'b0001000; req_i = 7'b0001000; step();
    do_ack(4, 8'h40, 8'h40, 7'b0001000, "R6 vectored");
    step();
    do_ack(4, 8'hFF, 8'hFF, 7'b0001000, "R6 R8 max id");
    req_i = '0; vec_mode_i = '0; step(); step();

    cur_mask_i = 7; req_i = 7'b0111111; step();
    check("R2 mask7 blocks", 32'(irq_o), 0);
    step();
    check("R2 mask7 still blocks", 32'(irq_o), 0);
    req_i = 7'b1111111; step();
    do_ack(7, 8'd31, 8'h00, 7'b1111111, "R4 R7 nmi");
    for (int i = 0; i < 4; i++) begin
      step();
      check("R4 held nmi not retaken", 32'(irq_o), 0);
    end
    req_i = '0; cur_mask_i = 0; step();

    ack_i = 1'b1; step();
    ack_i = 1'b0;
    check("R5 stray ack iack", 32'(iack_o), 0);
    step();
    check("R5 stray ack vec", 32'(vec_valid_o), 0);

    req_i = 7'b0000010; step();
    do_ack(2, 8'd26, 8'h00, 7'b1000010, "R10 lvl2");
    step();
    check("R10 nmi held irq", 32'(irq_o), 1);
    check("R10 nmi held lvl", 32'(irq_lvl_o), 7);
    do_ack(7, 8'd31, 8'h00, 7'b1000010, "R10 nmi");
    req_i = 7'b0000001; step(); step();
    do_ack(1, 8'd25, 8'h00, 7'b0000001, "R7 lvl1");
    req_i = '0;
    repeat (4) step();
    check("R6 scoreboard drained", 32'(exp_q.size()), 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule